// File: doc/BRIEF.md
# Double-Buffered Cursor Register Bank

This block holds the configuration words of a display cursor (a control word, a packed X/Y position, a base address and a compression-control word) in two copies. Host writes over a simple 32-bit register bus change only the staging copy. Nothing reaches the live copy, which drives the cursor hardware, until an update has been armed and a vertical-blank strobe arrives. At that strobe the armed staging values are copied into the live registers in a single step, so the displayed cursor never shows a mix of old and new settings.

Writing the base-address word arms a full update. Writing the control word or the compression word never arms anything. Any write other than the base address cancels an update that is already armed. Whether the position word arms itself depends on a mode input. In self-arming mode, a position write arms a position-only update, provided no control write has happened since the last commit. In strict mode, the position word always waits for a base-address write. Reads return the live copy. A status word reports whether an update is pending.

Top module: `curs_dbuf_bank`

## Requirements
- R1: While reset is asserted, and right after it, every live word, `arm_pending` and `rdata` are zero. The staging words are also zero: a base write of zero followed by a vblank, with no other write, leaves every live word zero.
- R2: A write to offset 0x8 (base address) sets `arm_pending` on the next cycle. At the next `vblank` strobe, all four staging words are copied into the live outputs, where they are visible one cycle after the strobe, and `arm_pending` clears.
- R3: A write to offset 0x0 (control) or 0xC (compression control) never arms an update. After such a write, `arm_pending` is 0 and a following `vblank` leaves the live words unchanged.
- R4: With `self_arm_mode`=1, a write to offset 0x4 (position) arms a position-only update if no control write has occurred since the last commit. At the next `vblank`, only the live position changes.
- R5: With `self_arm_mode`=1, if a control write occurred since the last commit, a position write does not arm. The position value is committed by a later base write and `vblank`, together with the other words.
- R6: With `self_arm_mode`=0, a position write never arms an update.
- R7: A write to 0x0, 0x4 or 0xC while an update is armed cancels that update, so the live words keep their old values at the next `vblank`. The only exception is the self-arming position case of R4, which replaces the armed update with a position-only one.
- R8: The live outputs change only in the cycle after a `vblank` strobe. Writes between strobes affect only the staging words.
- R9: When a base write and `vblank` fall in the same cycle, that `vblank` commits only what was armed before. The new arm stays pending and takes effect at the following `vblank`, with the newly written base.
- R10: A read is registered: `rdata` shows its result on the cycle after `rd_en` and otherwise holds its value. Offsets 0x0, 0x4, 0x8 and 0xC return the live control, position as {Y[31:16], X[15:0]}, base and compression words. Offset 0x10 returns `arm_pending` in bit 0, with all other bits zero.
- R11: Any other address reads as zero. Writing to any other address changes neither the staging words nor the arm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one access |
| rd_en | input | 1 | Read strobe for one access |
| addr | input | 5 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| vblank | input | 1 | Vertical-blank strobe, one cycle |
| self_arm_mode | input | 1 | 1: position write may arm itself; 0: strict |
| live_ctrl | output | 32 | Live control word |
| live_pos_x | output | 16 | Live signed X position |
| live_pos_y | output | 16 | Live signed Y position |
| live_base | output | 32 | Live base address |
| live_cmp | output | 32 | Live compression-control word |
| arm_pending | output | 1 | An armed update waits for vblank |

## Verification
Every result of this block is due exactly one clock after the input that causes it:
- `arm_pending` after the write that arms or cancels an update;
- the live words after the `vblank` strobe that commits them;
- `rdata` after `rd_en`.

The bench drives all inputs on the falling edge. It advances a reference model once per rising edge, with the commit applied before the write, as the same-cycle rule R9 requires. It then compares every output on the next falling edge, so each check samples exactly one register stage after its stimulus. Both the directed sequences and the seeded random stretch go through this single step routine, so none of the checks can look at an output before or after its due cycle.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int NREG     = 4;
  localparam int IDX_CTL  = 0;
  localparam int IDX_POS  = 1;
  localparam int IDX_BASE = 2;
  localparam int IDX_CMP  = 3;
  localparam int STAT_OFS = 16;

  typedef struct packed {
    logic full;      // all staged words armed by base write
    logic pos_only;  // position self-armed
    logic ctl_seen;  // control written since last commit
  } arm_state_t;
endpackage

// File: rtl/curs_addr_dec.sv
module curs_addr_dec
  import curs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_vec,
  output logic [NREG-1:0]   rd_vec,
  output logic              rd_stat
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(i * 4);
    assign wr_vec[i] = wr_en && (addr == REG_ADDR);
    assign rd_vec[i] = rd_en && (addr == REG_ADDR);
  end

  assign rd_stat = rd_en && (addr == STAT_ADDR);
endmodule

// File: rtl/curs_arm_ctrl.sv
module curs_arm_ctrl
  import curs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vblank,
  input  logic            self_arm_mode,
  input  logic [NREG-1:0] wr_vec,
  output logic            commit_all,
  output logic            commit_pos,
  output logic            pending
);
  arm_state_t st_q, st_d;
  logic       st_en;

  assign commit_all = vblank && st_q.full;
  assign commit_pos = vblank && !st_q.full && st_q.pos_only;
  assign pending    = st_q.full || st_q.pos_only;
  assign st_en      = vblank || (|wr_vec);

  always_comb begin
    st_d = st_q;
    // commit first: this vblank only acts on the state already armed
    if (commit_all || commit_pos) begin
      st_d.full     = 1'b0;
      st_d.pos_only = 1'b0;
      st_d.ctl_seen = 1'b0;
    end
    if (wr_vec[IDX_BASE]) begin
      st_d.full     = 1'b1;
      st_d.pos_only = 1'b0;
    end
    if (wr_vec[IDX_CTL]) begin
      st_d.full     = 1'b0;
      st_d.pos_only = 1'b0;
      st_d.ctl_seen = 1'b1;
    end
    if (wr_vec[IDX_CMP]) begin
      st_d.full     = 1'b0;
      st_d.pos_only = 1'b0;
    end
    if (wr_vec[IDX_POS]) begin
      st_d.full     = 1'b0;
      st_d.pos_only = self_arm_mode && !st_d.ctl_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/curs_reg_bank.sv
module curs_reg_bank
  import curs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG-1:0]               wr_vec,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          commit_all,
  input  logic                          commit_pos,
  output logic [NREG-1:0][DATA_W-1:0]   live_q
);
  logic [NREG-1:0][DATA_W-1:0] stage_q;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    logic              stage_en;
    logic              live_en;
    logic [DATA_W-1:0] stage_d;
    logic [DATA_W-1:0] live_d;

    assign stage_en = wr_vec[i];
    assign stage_d  = wdata;
    assign live_d   = stage_q[i];

    if (i == IDX_POS) begin : g_pos
      assign live_en = commit_all || commit_pos;
    end else begin : g_other
      assign live_en = commit_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
      end else if (stage_en) begin
        stage_q[i] <= stage_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[i] <= '0;
      end else if (live_en) begin
        live_q[i] <= live_d;
      end
    end
  end
endmodule

// File: rtl/curs_rd_port.sv
module curs_rd_port
  import curs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [NREG-1:0]             rd_vec,
  input  logic                        rd_stat,
  input  logic [NREG-1:0][DATA_W-1:0] live_q,
  input  logic                        pending,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_vec[i]) rd_d = rd_d | live_q[i];
    end
    if (rd_stat) rd_d = rd_d | DATA_W'(pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_d;
    end
  end
endmodule

// File: rtl/curs_dbuf_bank.sv
module curs_dbuf_bank
  import curs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              vblank,
  input  logic              self_arm_mode,
  output logic [DATA_W-1:0] live_ctrl,
  output logic [POS_W-1:0]  live_pos_x,
  output logic [POS_W-1:0]  live_pos_y,
  output logic [DATA_W-1:0] live_base,
  output logic [DATA_W-1:0] live_cmp,
  output logic              arm_pending
);
  localparam int POS_HI = 2 * POS_W;

  logic [NREG-1:0]             wr_vec;
  logic [NREG-1:0]             rd_vec;
  logic                        rd_stat;
  logic                        commit_all;
  logic                        commit_pos;
  logic [NREG-1:0][DATA_W-1:0] live_q;

  curs_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_vec  (wr_vec),
    .rd_vec  (rd_vec),
    .rd_stat (rd_stat)
  );

  curs_arm_ctrl u_arm (
    .clk           (clk),
    .rst_n         (rst_n),
    .vblank        (vblank),
    .self_arm_mode (self_arm_mode),
    .wr_vec        (wr_vec),
    .commit_all    (commit_all),
    .commit_pos    (commit_pos),
    .pending       (arm_pending)
  );

  curs_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_vec     (wr_vec),
    .wdata      (wdata),
    .commit_all (commit_all),
    .commit_pos (commit_pos),
    .live_q     (live_q)
  );

  curs_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_vec  (rd_vec),
    .rd_stat (rd_stat),
    .live_q  (live_q),
    .pending (arm_pending),
    .rdata   (rdata)
  );

  assign live_ctrl  = live_q[IDX_CTL];
  assign live_pos_x = live_q[IDX_POS][POS_W-1:0];
  assign live_pos_y = live_q[IDX_POS][POS_HI-1:POS_W];
  assign live_base  = live_q[IDX_BASE];
  assign live_cmp   = live_q[IDX_CMP];
endmodule

// File: rtl/curs_dbuf_chk.sv
module curs_dbuf_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int POS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              vblank,
  input logic              self_arm_mode,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] live_ctrl,
  input logic [POS_W-1:0]  live_pos_x,
  input logic [POS_W-1:0]  live_pos_y,
  input logic [DATA_W-1:0] live_base,
  input logic [DATA_W-1:0] live_cmp,
  input logic              arm_pending
);
  logic [4*DATA_W-1:0] live_all;
  logic wr_ctl, wr_pos, wr_base, wr_cmp;

  assign live_all = {live_ctrl, live_pos_y, live_pos_x, live_base, live_cmp};
  assign wr_ctl   = wr_en && (addr == ADDR_W'(0));
  assign wr_pos   = wr_en && (addr == ADDR_W'(4));
  assign wr_base  = wr_en && (addr == ADDR_W'(8));
  assign wr_cmp   = wr_en && (addr == ADDR_W'(12));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (live_all == '0 && !arm_pending && rdata == '0)
        else $error("reset state not clear");
    end
  end

  assert_base_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> arm_pending);

  assert_commit_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && arm_pending && !wr_en) |=> !arm_pending);

  assert_no_self_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl || wr_cmp) |=> !arm_pending);

  assert_strict_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pos && !self_arm_mode) |=> !arm_pending);

  assert_idle_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !arm_pending) |=> $stable(live_all));

  assert_live_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(live_all));

  assert_same_cycle_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && vblank) |=> arm_pending);
endmodule

bind curs_dbuf_bank curs_dbuf_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POS_W(POS_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .addr          (addr),
  .vblank        (vblank),
  .self_arm_mode (self_arm_mode),
  .rdata         (rdata),
  .live_ctrl     (live_ctrl),
  .live_pos_x    (live_pos_x),
  .live_pos_y    (live_pos_y),
  .live_base     (live_base),
  .live_cmp      (live_cmp),
  .arm_pending   (arm_pending)
);

// File: tb/tb_curs_dbuf_bank.sv
`timescale 1ns/1ps
module tb_curs_dbuf_bank;
  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en, vblank, self_arm_mode;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, live_ctrl, live_base, live_cmp;
  logic [15:0] live_pos_x, live_pos_y;
  logic        arm_pending;

  curs_dbuf_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vblank(vblank), .self_arm_mode(self_arm_mode),
    .live_ctrl(live_ctrl), .live_pos_x(live_pos_x), .live_pos_y(live_pos_y),
    .live_base(live_base), .live_cmp(live_cmp), .arm_pending(arm_pending)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string tag    = "R1";

  // reference model
  logic [31:0] m_stage [4];
  logic [31:0] m_live  [4];
  bit          m_full, m_pos, m_ctl_seen;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [4:0] a);
    if (a[1:0] == 2'b00 && a < 5'd16) return m_live[a[3:2]];
    if (a == 5'd16) return {31'b0, (m_full || m_pos)};
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_live[i] = '0; end
    m_full = 0; m_pos = 0; m_ctl_seen = 0; m_rdata = '0;
  endtask

  task automatic model_step();
    int idx;
    if (rd_en) m_rdata = model_read(addr);
    if (vblank && (m_full || m_pos)) begin
      if (m_full) for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
      else m_live[1] = m_stage[1];
      m_full = 0; m_pos = 0; m_ctl_seen = 0;
    end
    if (wr_en && addr[1:0] == 2'b00 && addr < 5'd16) begin
      idx = int'(addr[3:2]);
      m_stage[idx] = wdata;
      case (idx)
        0: begin m_full = 0; m_pos = 0; m_ctl_seen = 1; end
        1: begin m_full = 0; m_pos = self_arm_mode && !m_ctl_seen; end
        2: begin m_full = 1; m_pos = 0; end
        default: begin m_full = 0; m_pos = 0; end
      endcase
    end
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("live_ctrl", live_ctrl, m_live[0]);
    check("live_pos", {live_pos_y, live_pos_x}, m_live[1]);
    check("live_base", live_base, m_live[2]);
    check("live_cmp", live_cmp, m_live[3]);
    check("arm_pending", {31'b0, arm_pending}, {31'b0, (m_full || m_pos)});
    check("rdata", rdata, m_rdata);
  endtask

  task automatic step(input bit w, input bit r, input logic [4:0] a,
                      input logic [31:0] d, input bit vb);
    wr_en = w; rd_en = r; addr = a; wdata = d; vblank = vb;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0);
  endtask

  task automatic vb();
    step(0, 0, 5'd0, 32'h0, 1);
  endtask

  task automatic rd(input logic [4:0] a);
    step(0, 1, a, 32'h0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 0; wr_en = 0; rd_en = 0; vblank = 0; self_arm_mode = 0;
    addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    rst_n = 1;
    rd(5'd16);
    step(1, 0, 5'd8, 32'h0, 0);
    vb();                                  // R1: staging was zero

    tag = "R2";                            // full update, strict mode
    wr(5'd0, 32'hC0DE_0001);
    wr(5'd4, {16'hFFF0, 16'h0012});        // Y=-16, X=18
    wr(5'd12, 32'h0000_00A5);
    wr(5'd8, 32'h1000_0000);
    tag = "R8";
    step(0, 0, 5'd0, 32'h0, 0);            // still old values
    tag = "R2";
    vb();

    tag = "R3";
    wr(5'd12, 32'h1111_2222);
    vb();
    wr(5'd0, 32'h3333_4444);               // sets control-seen flag
    vb();

    tag = "R6";
    self_arm_mode = 0;
    wr(5'd4, 32'h0005_0006);
    vb();

    tag = "R5";
    self_arm_mode = 1;
    wr(5'd4, 32'h0007_0008);               // control written since commit
    vb();
    wr(5'd8, 32'h2000_0000);
    vb();                                  // everything commits

    tag = "R4";
    wr(5'd12, 32'h5555_6666);
    wr(5'd4, {16'h8000, 16'h7FFF});
    vb();                                  // only position moves

    tag = "R7";
    self_arm_mode = 0;
    wr(5'd8, 32'h3000_0000);
    wr(5'd4, 32'h0001_0001);               // cancels
    vb();
    wr(5'd8, 32'h3100_0000);
    wr(5'd0, 32'h0BAD_0BAD);               // cancels
    vb();

    tag = "R9";
    wr(5'd8, 32'h4000_0000);
    step(1, 0, 5'd8, 32'h5000_0000, 1);
    vb();

    tag = "R10";
    for (int i = 0; i < 5; i++) rd(5'(i * 4));
    wr(5'd8, 32'h6000_0000);
    rd(5'd16);
    step(0, 0, 5'd16, 32'h0, 0);           // rdata holds without rd_en

    tag = "R11";
    wr(5'd2, 32'hDEAD_BEEF);
    wr(5'd20, 32'hDEAD_BEEF);
    rd(5'd2);
    rd(5'd24);
    vb();

    tag = "R8";                            // seeded random traffic
    for (int blk = 0; blk < 8; blk++) begin
      self_arm_mode = blk[0];
      for (int c = 0; c < 500; c++) begin
        logic [4:0] a;
        int sel;
        sel = $urandom_range(0, 9);
        case (sel)
          0, 1: a = 5'd0;
          2, 3: a = 5'd4;
          4, 5: a = 5'd8;
          6:    a = 5'd12;
          7:    a = 5'd16;
          8:    a = 5'd6;
          default: a = 5'd28;
        endcase
        step(($urandom_range(0, 1) == 1), ($urandom_range(0, 2) == 0), a,
             $urandom, ($urandom_range(0, 7) == 0));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule